// File: doc/BRIEF.md
# Snooping Set-Associative Cache Directory

This block holds the tags and line states of a four-way set-associative write-back data cache with 16-byte lines, and it also watches addresses seen on an external bus. The core side sends one request per cycle: a lookup, a fill or a write. One cycle after the directory accepts a request, the block reports whether it hit. On a hit it gives the way that matched. On a miss it gives the victim way and whether that victim line is dirty. The snoop side presents bus addresses, each with a flag saying whether the cycle may be snooped. A snoopable address that matches a resident line invalidates that line. If the line was dirty, the block raises a one-cycle pulse that carries the set and the way.

Both sides share one directory access per cycle, and a snoopable cycle always takes it. An arbiter state machine records which operation was granted in each cycle. It has five states: IDLE, SNOOP, LOOKUP, FILL and WRITE. From any state the next state is chosen as follows:
- SNOOP when a snoopable snoop is present.
- Otherwise LOOKUP, FILL or WRITE when a core request is present, following its opcode.
- Otherwise IDLE.

The response is valid while the state is LOOKUP, FILL or WRITE. Data storage, write-back sequencing and the bus protocol belong to neighbouring blocks.

Top module: `snp_dir_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) makes every line of every set invalid and clears every round-robin pointer. After reset, `rsp_valid` and `inv_dirty` are low, and the first lookup misses with victim way 0, not dirty.
- R2: Address bits [3:0] are ignored. Bits [9:4] select one of 64 sets and bits [31:10] form the tag. A lookup that differs only in bits [3:0] hits the same line. The same tag under a different index misses.
- R3: A core request is accepted at a rising edge where `core_valid` and `core_ready` are both high. Exactly in the next cycle `rsp_valid` is high, and it is low after any cycle with no acceptance. `rsp_hit` is high only when some way of the set is non-invalid with an equal tag, and then `rsp_way` is that way. Opcodes: 2'b00 lookup, 2'b01 fill, 2'b10 write, 2'b11 treated as lookup. A lookup changes no state.
- R4: A fill writes the new tag and the valid (clean) state into the hit way if the tag is already present, otherwise into the victim way. `rsp_way` reports the way written.
- R5: On a miss, the victim is the lowest-numbered invalid way. If no way is invalid, the victim is the set's 2-bit round-robin pointer, which increments (wrapping) on every fill to that set. `rsp_victim_dirty` is high on a miss whose victim is dirty and low on every hit.
- R6: A write that hits moves the line to dirty. A write that misses changes nothing.
- R7: A snoopable snoop whose address matches a resident line makes that line invalid.
- R8: When a snoop invalidates a dirty line, `inv_dirty` is high for exactly the next cycle, with `inv_set` and `inv_way` naming the line. Invalidating a clean line, or a snoop that misses, gives no pulse.
- R9: A snoop with `snoop_flag` low neither stalls the core nor changes any line.
- R10: While a snoopable snoop is presented, `core_ready` is low and the snoop is served. The stalled core request is accepted in the first cycle without such a snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| core_valid | input | 1 | Core request present |
| core_op | input | 2 | 00 lookup, 01 fill, 10 write, 11 lookup |
| core_addr | input | 32 | Core byte address |
| core_ready | output | 1 | Core request can be accepted this cycle |
| rsp_valid | output | 1 | Response for the request accepted last cycle |
| rsp_hit | output | 1 | Request hit a resident line |
| rsp_way | output | 2 | Hit way, or victim way on a miss |
| rsp_victim_dirty | output | 1 | Victim line is dirty (miss only) |
| snoop_valid | input | 1 | External bus address present |
| snoop_flag | input | 1 | Bus cycle is snoopable |
| snoop_addr | input | 32 | External bus byte address |
| inv_dirty | output | 1 | A dirty line was invalidated by the last snoop |
| inv_set | output | 6 | Set of the invalidated dirty line |
| inv_way | output | 2 | Way of the invalidated dirty line |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 4-bit offsets, 64 sets and 4 ways. Random traffic is limited to three sets and five tags. With that small address range, sets fill up, the round-robin pointer wraps, and dirty victims occur within a few hundred requests. Snoops land on lines that are resident or dirty and often collide with core requests in the same cycle. Directed cases cover the reset state, offsets being ignored, pointer order, and the stall-then-accept path.

// File: rtl/snp_dir_pkg.sv
package snp_dir_pkg;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'b00,
        OP_FILL   = 2'b01,
        OP_WRITE  = 2'b10,
        OP_RSVD   = 2'b11
    } core_op_e;

    typedef enum logic [1:0] {
        LN_INV   = 2'b00,
        LN_CLEAN = 2'b01,
        LN_DIRTY = 2'b11
    } line_st_e;

    typedef enum logic [2:0] {
        GR_IDLE   = 3'd0,
        GR_SNOOP  = 3'd1,
        GR_LOOKUP = 3'd2,
        GR_FILL   = 3'd3,
        GR_WRITE  = 3'd4
    } grant_e;

endpackage

// File: rtl/snp_dir_arb.sv
module snp_dir_arb
    import snp_dir_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       snoop_go,
    input  logic       core_valid,
    input  logic [1:0] core_op,
    output logic       core_ready,
    output grant_e     grant,
    output logic       rsp_phase
);

    grant_e state_q;

    // next-state: snoop first, then core by opcode
    always_comb begin
        grant = GR_IDLE;
        if (snoop_go) begin
            grant = GR_SNOOP;
        end else if (core_valid) begin
            unique case (core_op_e'(core_op))
                OP_FILL:  grant = GR_FILL;
                OP_WRITE: grant = GR_WRITE;
                default:  grant = GR_LOOKUP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= GR_IDLE;
        else     state_q <= grant;
    end

    always_comb begin
        unique case (state_q)
            GR_LOOKUP, GR_FILL, GR_WRITE: rsp_phase = 1'b1;
            GR_IDLE, GR_SNOOP:            rsp_phase = 1'b0;
            default:                      rsp_phase = 1'b0;
        endcase
    end

    assign core_ready = ~snoop_go;

endmodule

// File: rtl/snp_dir_array.sv
module snp_dir_array
    import snp_dir_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0][1:0]        rd_st,
    output logic [WAY_W-1:0]            rd_rr,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic                        wr_tag_en,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic [1:0]                  wr_st,
    input  logic                        rr_adv
);

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [1:0]       st_q  [SETS][WAYS];
    logic [WAY_W-1:0] rr_q  [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                rr_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) st_q[s][w] <= LN_INV;
            end
        end else begin
            if (wr_en)  st_q[wr_idx][wr_way] <= wr_st;
            if (rr_adv) rr_q[wr_idx] <= rr_q[wr_idx] + 1'b1;
        end
    end

    // tags carry no reset: an invalid state masks them
    always_ff @(posedge clk) begin
        if (wr_en && wr_tag_en) tag_q[wr_idx][wr_way] <= wr_tag;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tag[w] = tag_q[rd_idx][w];
        assign rd_st[w]  = st_q[rd_idx][w];
    end

    assign rd_rr = rr_q[rd_idx];

endmodule

// File: rtl/snp_dir_match.sv
module snp_dir_match
    import snp_dir_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [TAG_W-1:0]            look_tag,
    input  logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    input  logic [WAYS-1:0][1:0]        rd_st,
    input  logic [WAY_W-1:0]            rr_ptr,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic                        hit_dirty,
    output logic [WAY_W-1:0]            vic_way,
    output logic                        vic_dirty
);

    logic [WAYS-1:0] way_hit;
    logic [WAYS-1:0] way_free;
    logic [WAY_W-1:0] free_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_free[w] = (rd_st[w] == LN_INV);
        assign way_hit[w]  = !way_free[w] && (rd_tag[w] == look_tag);
    end

    // lowest index wins in both encoders
    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w])  hit_way  = WAY_W'(w);
            if (way_free[w]) free_way = WAY_W'(w);
        end
    end

    assign hit       = |way_hit;
    assign hit_dirty = (rd_st[hit_way] == LN_DIRTY);
    assign vic_way   = (|way_free) ? free_way : rr_ptr;
    assign vic_dirty = (rd_st[vic_way] == LN_DIRTY);

endmodule

// File: rtl/snp_dir_top.sv
module snp_dir_top
    import snp_dir_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4,
    parameter int SETS   = 64,
    parameter int WAYS   = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_valid,
    input  logic [1:0]        core_op,
    input  logic [ADDR_W-1:0] core_addr,
    output logic              core_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_victim_dirty,
    input  logic              snoop_valid,
    input  logic              snoop_flag,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              inv_dirty,
    output logic [IDX_W-1:0]  inv_set,
    output logic [WAY_W-1:0]  inv_way
);

    logic              snoop_go;
    logic [ADDR_W-1:0] sel_addr;
    logic [IDX_W-1:0]  sel_idx;
    logic [TAG_W-1:0]  sel_tag;
    logic              unused_off;
    grant_e            grant;

    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [WAYS-1:0][1:0]       rd_st;
    logic [WAY_W-1:0]           rd_rr;

    logic             hit, hit_dirty, vic_dirty;
    logic [WAY_W-1:0] hit_way, vic_way;

    logic             wr_en, wr_tag_en, rr_adv;
    logic [WAY_W-1:0] wr_way;
    logic [1:0]       wr_st;

    assign snoop_go   = snoop_valid & snoop_flag;
    assign sel_addr   = snoop_go ? snoop_addr : core_addr;
    assign sel_idx    = sel_addr[OFF_W +: IDX_W];
    assign sel_tag    = sel_addr[ADDR_W-1 -: TAG_W];
    assign unused_off = ^{core_addr[OFF_W-1:0], snoop_addr[OFF_W-1:0]};

    snp_dir_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .snoop_go   (snoop_go),
        .core_valid (core_valid),
        .core_op    (core_op),
        .core_ready (core_ready),
        .grant      (grant),
        .rsp_phase  (rsp_valid)
    );

    snp_dir_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_array (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (sel_idx),
        .rd_tag    (rd_tag),
        .rd_st     (rd_st),
        .rd_rr     (rd_rr),
        .wr_en     (wr_en),
        .wr_idx    (sel_idx),
        .wr_way    (wr_way),
        .wr_tag_en (wr_tag_en),
        .wr_tag    (sel_tag),
        .wr_st     (wr_st),
        .rr_adv    (rr_adv)
    );

    snp_dir_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .look_tag  (sel_tag),
        .rd_tag    (rd_tag),
        .rd_st     (rd_st),
        .rr_ptr    (rd_rr),
        .hit       (hit),
        .hit_way   (hit_way),
        .hit_dirty (hit_dirty),
        .vic_way   (vic_way),
        .vic_dirty (vic_dirty)
    );

    // state update for the granted operation
    always_comb begin
        wr_en     = 1'b0;
        wr_tag_en = 1'b0;
        rr_adv    = 1'b0;
        wr_way    = hit_way;
        wr_st     = LN_INV;
        unique case (grant)
            GR_SNOOP: begin
                wr_en = hit;
                wr_st = LN_INV;
            end
            GR_FILL: begin
                wr_en     = 1'b1;
                wr_tag_en = 1'b1;
                rr_adv    = 1'b1;
                wr_way    = hit ? hit_way : vic_way;
                wr_st     = LN_CLEAN;
            end
            GR_WRITE: begin
                wr_en = hit;
                wr_st = LN_DIRTY;
            end
            default: begin
                wr_en = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_hit          <= 1'b0;
            rsp_way          <= '0;
            rsp_victim_dirty <= 1'b0;
            inv_dirty        <= 1'b0;
            inv_set          <= '0;
            inv_way          <= '0;
        end else begin
            if (grant == GR_LOOKUP || grant == GR_FILL || grant == GR_WRITE) begin
                rsp_hit          <= hit;
                rsp_way          <= hit ? hit_way : vic_way;
                rsp_victim_dirty <= !hit && vic_dirty;
            end else begin
                rsp_hit          <= 1'b0;
                rsp_victim_dirty <= 1'b0;
            end
            inv_dirty <= (grant == GR_SNOOP) && hit && hit_dirty;
            if (grant == GR_SNOOP) begin
                inv_set <= sel_idx;
                inv_way <= hit_way;
            end
        end
    end

endmodule

// File: rtl/snp_dir_chk.sv
module snp_dir_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             core_valid,
    input logic             core_ready,
    input logic             snoop_valid,
    input logic             snoop_flag,
    input logic [IDX_W-1:0] snoop_idx,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_victim_dirty,
    input logic             inv_dirty,
    input logic [IDX_W-1:0] inv_set
);

    AST_SNOOP_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && snoop_flag) |-> !core_ready); // R10

    AST_PLAIN_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && !snoop_flag) |-> core_ready); // R9

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (core_valid && core_ready) |=> rsp_valid); // R3

    AST_RSP_ONLY_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
        !(core_valid && core_ready) |=> !rsp_valid); // R3

    AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid); // R3

    AST_HIT_NO_VICTIM: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> !rsp_victim_dirty); // R5

    AST_PULSE_FROM_SNOOP: assert property (@(posedge clk) disable iff (rst)
        (!snoop_valid || !snoop_flag) |=> !inv_dirty); // R8

    AST_PULSE_SET: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && snoop_flag) |=> (!inv_dirty || inv_set == $past(snoop_idx))); // R8

endmodule

bind snp_dir_top snp_dir_chk #(.IDX_W(IDX_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .core_valid       (core_valid),
    .core_ready       (core_ready),
    .snoop_valid      (snoop_valid),
    .snoop_flag       (snoop_flag),
    .snoop_idx        (snoop_addr[OFF_W +: IDX_W]),
    .rsp_valid        (rsp_valid),
    .rsp_hit          (rsp_hit),
    .rsp_victim_dirty (rsp_victim_dirty),
    .inv_dirty        (inv_dirty),
    .inv_set          (inv_set)
);

// File: tb/tb_snp_dir_top.sv
`timescale 1ns/1ps
module tb_snp_dir_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        core_valid = 1'b0;
    logic [1:0]  core_op = 2'b00;
    logic [31:0] core_addr = '0;
    logic        core_ready;
    logic        rsp_valid, rsp_hit, rsp_victim_dirty;
    logic [1:0]  rsp_way;
    logic        snoop_valid = 1'b0;
    logic        snoop_flag = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic        inv_dirty;
    logic [5:0]  inv_set;
    logic [1:0]  inv_way;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    snp_dir_top dut (
        .clk(clk), .rst(rst),
        .core_valid(core_valid), .core_op(core_op), .core_addr(core_addr),
        .core_ready(core_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_victim_dirty(rsp_victim_dirty),
        .snoop_valid(snoop_valid), .snoop_flag(snoop_flag), .snoop_addr(snoop_addr),
        .inv_dirty(inv_dirty), .inv_set(inv_set), .inv_way(inv_way)
    );

    // model: 0 invalid, 1 clean, 2 dirty
    logic [21:0] mtag [64][4];
    int          mst  [64][4];
    int          mrr  [64];

    bit    e_rv, e_hit, e_vd, e_inv;
    int    e_way, e_iset, e_iway;
    string e_rq;

    function automatic logic [31:0] mk(int tag, int set, int off);
        return {22'(tag), 6'(set), 4'(off)};
    endfunction

    function automatic int m_hit(int s, logic [21:0] t);
        for (int w = 0; w < 4; w++)
            if (mst[s][w] != 0 && mtag[s][w] == t) return w;
        return -1;
    endfunction

    function automatic int m_vic(int s);
        for (int w = 0; w < 4; w++)
            if (mst[s][w] == 0) return w;
        return mrr[s];
    endfunction

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic step(bit cv, logic [1:0] op, logic [31:0] ca,
                        bit sv, bit sf, logic [31:0] sa, string rq);
        int s, h, v, w;
        @(negedge clk);
        chk(rsp_valid == e_rv, "R3", "rsp_valid", rsp_valid, e_rv);
        if (e_rv) begin
            chk(rsp_hit == e_hit, e_rq, "rsp_hit", rsp_hit, e_hit);
            chk(rsp_way == 2'(e_way), e_rq, "rsp_way", rsp_way, e_way);
            chk(rsp_victim_dirty == e_vd, "R5", "rsp_victim_dirty", rsp_victim_dirty, e_vd);
        end
        chk(inv_dirty == e_inv, "R8", "inv_dirty", inv_dirty, e_inv);
        if (e_inv) begin
            chk(inv_set == 6'(e_iset), "R8", "inv_set", inv_set, e_iset);
            chk(inv_way == 2'(e_iway), "R8", "inv_way", inv_way, e_iway);
        end
        core_valid = cv; core_op = op; core_addr = ca;
        snoop_valid = sv; snoop_flag = sf; snoop_addr = sa;
        #1;
        chk(core_ready == !(sv && sf), (sv && sf) ? "R10" : "R9", "core_ready",
            core_ready, !(sv && sf));
        e_rv = 0; e_inv = 0;
        if (sv && sf) begin
            s = int'(sa[9:4]);
            h = m_hit(s, sa[31:10]);
            if (h >= 0) begin
                if (mst[s][h] == 2) begin
                    e_inv = 1; e_iset = s; e_iway = h;
                end
                mst[s][h] = 0;
            end
        end else if (cv) begin
            s = int'(ca[9:4]);
            h = m_hit(s, ca[31:10]);
            v = m_vic(s);
            e_rv  = 1;
            e_hit = (h >= 0);
            e_way = e_hit ? h : v;
            e_vd  = !e_hit && (mst[s][v] == 2);
            if (op == 2'b01) begin
                w = e_hit ? h : v;
                mtag[s][w] = ca[31:10];
                mst[s][w]  = 1;
                mrr[s]     = (mrr[s] + 1) % 4;
            end else if (op == 2'b10) begin
                if (e_hit) mst[s][h] = 2;
            end
            if (rq != "") e_rq = rq;
            else if (op == 2'b01) e_rq = "R4";
            else if (op == 2'b10) e_rq = "R6";
            else e_rq = "R3";
        end
    endtask

    task automatic idle(string rq);
        step(0, 2'b00, '0, 0, 0, '0, rq);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog run did not finish");
        summary();
    end

    initial begin
        for (int s = 0; s < 64; s++) begin
            mrr[s] = 0;
            for (int w = 0; w < 4; w++) begin mst[s][w] = 0; mtag[s][w] = '0; end
        end
        e_rv = 0; e_inv = 0; e_rq = "R3";
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
        chk(inv_dirty == 0, "R1", "inv_dirty after reset", inv_dirty, 0);
        chk(core_ready == 1, "R1", "core_ready after reset", core_ready, 1);

        // R1: empty directory
        step(1, 2'b00, mk(1, 5, 0), 0, 0, '0, "R1");
        // R4: fill four ways of set 5
        for (int t = 1; t <= 4; t++) step(1, 2'b01, mk(t, 5, t), 0, 0, '0, "R4");
        // R2: offset ignored, index matters
        step(1, 2'b00, mk(3, 5, 15), 0, 0, '0, "R2");
        step(1, 2'b00, mk(3, 6, 0), 0, 0, '0, "R2");
        // R6: write hit -> dirty
        step(1, 2'b10, mk(2, 5, 0), 0, 0, '0, "R6");
        step(1, 2'b10, mk(7, 5, 0), 0, 0, '0, "R6");
        // R5: full set, pointer wrapped to 0, then 1 (dirty victim)
        step(1, 2'b01, mk(9, 5, 0), 0, 0, '0, "R5");
        step(1, 2'b00, mk(11, 5, 0), 0, 0, '0, "R5");
        step(1, 2'b01, mk(10, 5, 0), 0, 0, '0, "R5");
        // R9: nonsnoopable does nothing
        step(1, 2'b10, mk(3, 5, 0), 0, 0, '0, "R6");
        step(1, 2'b00, mk(4, 5, 0), 1, 0, mk(3, 5, 0), "R9");
        step(1, 2'b00, mk(3, 5, 0), 0, 0, '0, "R9");
        // R10: snoop wins, core waits one cycle; R8 dirty pulse
        step(1, 2'b00, mk(4, 5, 0), 1, 1, mk(3, 5, 8), "R10");
        step(1, 2'b00, mk(4, 5, 0), 0, 0, '0, "R10");
        // R7: invalidated line now misses, victim is that way
        step(1, 2'b00, mk(3, 5, 0), 0, 0, '0, "R7");
        // R8: clean invalidate gives no pulse
        step(0, 2'b00, '0, 1, 1, mk(4, 5, 0), "R8");
        step(1, 2'b00, mk(4, 5, 0), 0, 0, '0, "R7");
        idle("R3");

        // constrained random
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 3000; i++) begin
            bit          cv, sv, sf;
            logic [1:0]  op;
            logic [31:0] ca, sa;
            cv = ($urandom % 10) < 8;
            op = 2'($urandom % 4);
            ca = mk($urandom % 5, $urandom % 3, $urandom % 16);
            sv = ($urandom % 10) < 3;
            sf = ($urandom % 10) < 7;
            sa = mk($urandom % 5, $urandom % 3, $urandom % 16);
            step(cv, op, ca, sv, sf, sa, "");
        end
        idle("R3");
        idle("R3");
        summary();
    end

endmodule